// File: doc/BRIEF.md
# Dual-Rail Carry Completion Adder

This block adds two unsigned words plus a carry-in and reports by itself when the result is final. The operands are plain binary words. The carry leaving each bit position is held on two rails. One rail says "a carry leaves this position" and the other says "no carry leaves this position". While both rails are low, the position has not yet decided. A position counts as done once either of its rails is set. The whole addition counts as finished once every position is done.

Carry settling is modelled in clock cycles. A position whose two operand bits are equal decides on the first clock after enable. Bits 1,1 give a carry and bits 0,0 give no carry. A position whose bits differ must copy the decision of the position below it, one clock after that lower position decides. Bit 0 copies carry-in. The time to finish therefore follows the longest run of differing bits, not the word width.

The user sets the operands, then raises enable and holds operands and enable steady until finish is seen. Dropping enable clears every rail at the next clock. Enable must stay low across at least one rising edge before the next operation starts.

Top module: `ccs_adder`

## Requirements
- R1: After reset, finish_o and err_o are 0.
- R2: While en_i is 0, finish_o is 0 in the same cycle, including the cycle in which en_i falls.
- R3: Take t(i) = 1 when i = 0, or when bits a[i] and b[i] are equal. Otherwise take t(i) = t(i-1) + 1. Then finish_o rises exactly max(t) rising edges after the edge that first samples en_i high.
- R4: When finish_o is 1, {cout_o, sum_o} equals a_i + b_i + cin_i.
- R5: When every bit pair is equal (a_i == b_i), finish_o rises after one edge.
- R6: When every bit pair differs, finish_o rises only after WIDTH edges. cout_o then equals cin_i.
- R7: err_o is never 1. It would flag a position with both carry rails set.
- R8: While en_i stays 1 and operands are held, finish_o stays 1 once set, and sum_o and cout_o do not change.
- R9: In the cycle where en_i rises, after at least one edge with en_i low, finish_o is 0. A previous result does not leak into the new operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Start/hold the addition; low clears all carry rails |
| a_i | input | WIDTH | Operand A |
| b_i | input | WIDTH | Operand B |
| cin_i | input | 1 | Carry into bit 0 |
| sum_o | output | WIDTH | Sum bits, valid while finish_o is 1 |
| cout_o | output | 1 | Carry out of the top bit |
| finish_o | output | 1 | All positions have decided their carry |
| err_o | output | 1 | Some position has both carry rails set |

## Verification
The hardest case to reach is the worst-case settling time. In that case, a carry decided at bit 0 must walk up through every position before finish can rise. The stimulus reaches it with operands whose bits differ at every position, such as all ones plus zero and alternating patterns. It runs each of them with both carry-in values. Mixed operands from a shift-register sequence create runs of differing bits of many lengths. For each operation, the scoreboard predicts the exact finish cycle from the run lengths.

// File: rtl/ccs_pkg.sv
package ccs_pkg;
  typedef struct packed {
    logic carry;    // a carry leaves this position
    logic no_carry; // no carry leaves this position
  } rail_t;

  localparam rail_t RAIL_OPEN = '{carry: 1'b0, no_carry: 1'b0};
  localparam rail_t RAIL_GEN  = '{carry: 1'b1, no_carry: 1'b0};
  localparam rail_t RAIL_KILL = '{carry: 1'b0, no_carry: 1'b1};

  function automatic logic rail_known(rail_t r);
    return r.carry | r.no_carry;
  endfunction
endpackage

// File: rtl/ccs_stage.sv
module ccs_stage
  import ccs_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  en_i,
  input  logic  a_i,
  input  logic  b_i,
  input  rail_t lower_i,
  output rail_t rail_o
);
  rail_t rail_q, rail_d;

  always_comb begin
    rail_d = rail_q;
    if (!en_i) begin
      rail_d = RAIL_OPEN;
    end else if (!rail_known(rail_q)) begin
      if (a_i & b_i)        rail_d = RAIL_GEN;
      else if (!a_i & !b_i) rail_d = RAIL_KILL;
      else                  rail_d = lower_i; // propagate: follow lower position
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rail_q <= RAIL_OPEN;
    else         rail_q <= rail_d;
  end

  assign rail_o = rail_q;
endmodule

// File: rtl/ccs_detect.sv
module ccs_detect #(
  parameter int WIDTH = 16
) (
  input  logic             en_i,
  input  logic [WIDTH-1:0] carry_i,
  input  logic [WIDTH-1:0] no_carry_i,
  output logic             finish_o,
  output logic             err_o
);
  logic [WIDTH-1:0] pos_done;
  logic [WIDTH-1:0] pos_bad;

  assign pos_done = carry_i | no_carry_i;
  assign pos_bad  = carry_i & no_carry_i;
  assign finish_o = en_i & (&pos_done);
  assign err_o    = |pos_bad;
endmodule

// File: rtl/ccs_sum.sv
module ccs_sum #(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  input  logic [WIDTH-1:0] carry_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o
);
  logic [WIDTH-1:0] cin_vec;

  generate
    if (WIDTH > 1) begin : g_wide
      assign cin_vec = {carry_i[WIDTH-2:0], cin_i};
    end else begin : g_one
      assign cin_vec = cin_i;
    end
  endgenerate

  assign sum_o  = a_i ^ b_i ^ cin_vec;
  assign cout_o = carry_i[WIDTH-1];
endmodule

// File: rtl/ccs_adder.sv
module ccs_adder
  import ccs_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  input  logic             cin_i,
  output logic [WIDTH-1:0] sum_o,
  output logic             cout_o,
  output logic             finish_o,
  output logic             err_o
);
  rail_t            rail [WIDTH];
  rail_t            cin_rail;
  logic [WIDTH-1:0] carry_vec;
  logic [WIDTH-1:0] no_carry_vec;

  assign cin_rail = cin_i ? RAIL_GEN : RAIL_KILL;

  generate
    for (genvar i = 0; i < WIDTH; i++) begin : g_pos
      rail_t lower;
      if (i == 0) begin : g_base
        assign lower = cin_rail;
      end else begin : g_chain
        assign lower = rail[i-1];
      end

      ccs_stage i_stage (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .en_i   (en_i),
        .a_i    (a_i[i]),
        .b_i    (b_i[i]),
        .lower_i(lower),
        .rail_o (rail[i])
      );

      assign carry_vec[i]    = rail[i].carry;
      assign no_carry_vec[i] = rail[i].no_carry;
    end
  endgenerate

  ccs_detect #(.WIDTH(WIDTH)) i_detect (
    .en_i      (en_i),
    .carry_i   (carry_vec),
    .no_carry_i(no_carry_vec),
    .finish_o  (finish_o),
    .err_o     (err_o)
  );

  ccs_sum #(.WIDTH(WIDTH)) i_sum (
    .a_i    (a_i),
    .b_i    (b_i),
    .cin_i  (cin_i),
    .carry_i(carry_vec),
    .sum_o  (sum_o),
    .cout_o (cout_o)
  );
endmodule

// File: rtl/ccs_adder_chk.sv
module ccs_adder_chk #(
  parameter int WIDTH = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic [WIDTH-1:0] a_i,
  input logic [WIDTH-1:0] b_i,
  input logic             cin_i,
  input logic [WIDTH-1:0] sum_o,
  input logic             cout_o,
  input logic             finish_o,
  input logic             err_o
);
  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !finish_o);

  assert_rails_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !err_o);

  assert_sum_exact_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish_o |-> ({cout_o, sum_o} == ({1'b0, a_i} + {1'b0, b_i} + {{WIDTH{1'b0}}, cin_i})));

  assert_result_held_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && finish_o && $stable(a_i)) |=>
      (!en_i || !$stable(a_i) || !$stable(b_i) || !$stable(cin_i) ||
       (finish_o && $stable(sum_o) && $stable(cout_o))));

  assert_no_stale_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(en_i) |-> !finish_o);
endmodule

bind ccs_adder ccs_adder_chk #(.WIDTH(WIDTH)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .a_i     (a_i),
  .b_i     (b_i),
  .cin_i   (cin_i),
  .sum_o   (sum_o),
  .cout_o  (cout_o),
  .finish_o(finish_o),
  .err_o   (err_o)
);

// File: tb/test_ccs_adder.sv
`timescale 1ns/1ps
module test_ccs_adder;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         en = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [W-1:0] sum;
  logic         cout;
  logic         finish;
  logic         err;

  int total = 0;
  int bad   = 0;

  typedef struct {
    logic [W-1:0] s;
    logic         c;
    int           lat;
    string        tag;
  } exp_t;
  exp_t q[$];

  logic  seen = 1'b0;
  int    cnt  = 0;
  exp_t  cur;

  always #5 clk = ~clk;

  ccs_adder #(.WIDTH(W)) i_ccs_adder (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .a_i(a), .b_i(b), .cin_i(cin),
    .sum_o(sum), .cout_o(cout), .finish_o(finish), .err_o(err)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic int model_lat(input logic [W-1:0] x, input logic [W-1:0] y);
    int t = 0;
    int m = 0;
    for (int i = 0; i < W; i++) begin
      if (i == 0 || x[i] == y[i]) t = 1;
      else                        t = t + 1;
      if (t > m) m = t;
    end
    return m;
  endfunction

  // monitor: sample away from the active edge
  always @(negedge clk) begin
    if (rst_n && en) begin
      if (!seen) begin
        if (cnt == 0)
          check(finish == 1'b0, "R9", "finish at enable cycle", finish, 0);
        if (finish) begin
          cur  = q.pop_front();
          seen = 1'b1;
          check(cnt == cur.lat, "R3", {cur.tag, " finish latency"}, cnt, cur.lat);
          check(sum == cur.s, "R4", {cur.tag, " sum"}, sum, cur.s);
          check(cout == cur.c, "R4", {cur.tag, " cout"}, cout, cur.c);
          if (cur.tag == "gen_kill") check(cnt == 1, "R5", "one-edge finish", cnt, 1);
          if (cur.tag == "all_prop") begin
            check(cnt == W, "R6", "full-walk finish", cnt, W);
            check(cout == cin, "R6", "cout equals cin", cout, cin);
          end
        end
      end else begin
        check(finish && sum == cur.s && cout == cur.c, "R8", "result held",
              {cout, sum}, {cur.c, cur.s});
      end
      check(err == 1'b0, "R7", "err flag", err, 0);
      cnt++;
    end
  end

  task automatic run_op(input logic [W-1:0] x, input logic [W-1:0] y,
                        input logic ci, input string tag);
    exp_t e;
    logic [W:0] full;
    full  = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, ci};
    e.s   = full[W-1:0];
    e.c   = full[W];
    e.lat = model_lat(x, y);
    e.tag = tag;
    q.push_back(e);
    @(posedge clk); #1;
    a = x; b = y; cin = ci;
    @(posedge clk); #1;
    seen = 1'b0; cnt = 0; en = 1'b1;
    while (!seen) @(negedge clk);
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    en = 1'b0;
    @(negedge clk);
    check(finish == 1'b0, "R2", "finish after enable drop", finish, 0);
    @(negedge clk);
    check(finish == 1'b0, "R2", "finish while idle", finish, 0);
  endtask

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(negedge clk);
    check(finish == 1'b0, "R1", "finish in reset", finish, 0);
    check(err == 1'b0, "R1", "err in reset", err, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(finish == 1'b0 && err == 1'b0, "R1", "flags after reset", {finish, err}, 0);

    run_op(16'd1, 16'd2, 1'b0, "small");
    run_op(16'hFFFF, 16'h0000, 1'b1, "all_prop");
    run_op(16'hFFFF, 16'h0000, 1'b0, "all_prop");
    run_op(16'h5555, 16'hAAAA, 1'b1, "all_prop");
    run_op(16'h5555, 16'hAAAA, 1'b0, "all_prop");
    run_op(16'h3C3C, 16'h3C3C, 1'b1, "gen_kill");
    run_op(16'h0000, 16'h0000, 1'b0, "gen_kill");
    run_op(16'hFFFF, 16'hFFFF, 1'b1, "gen_kill");
    run_op(16'hFFFF, 16'h0001, 1'b0, "wrap");
    run_op(16'h00FF, 16'h0100, 1'b1, "mid_run");
    lfsr = 16'hACE1;
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] x;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      x    = lfsr;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      run_op(x, lfsr, lfsr[3], "mixed");
    end
    check(q.size() == 0, "R3", "scoreboard drained", q.size(), 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R3 watchdog actual=%0d expected=%0d", 1, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule